// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps the eight most useful virtual-to-physical page translations next to a page table walker. A requester presents a 20-bit virtual page number, an 8-bit address-space tag and the kind of access (read or write, user or supervisor). If a valid entry holds that page and tag, the block answers in the same cycle with hit, the frame number and the stored permission bits. No page table access is made on a hit.

When no entry matches, the block reports a miss. It hands the page and tag to the walker and holds the request until the walker returns a fill. The fill is then written into an entry: one already holding that page and tag is reused, otherwise the lowest-numbered empty entry, and otherwise the entry under a rotating pointer. A write to a writable page whose dirty bit is still clear is also treated as a miss, so that the walker can set the dirty bit and refill the entry.

Because every entry carries its address-space tag, a context switch does not require emptying the cache. Software-driven maintenance can remove one page (under every tag), every entry of one tag, or everything.

The walker control is a two-state machine:
- `ST_IDLE` moves to `ST_WALK` on a valid lookup that misses (transition *launch*).
- `ST_WALK` returns to `ST_IDLE` on the cycle `fill_valid` is high (transition *complete*).
- Every other case stays in the current state (transition *hold*).

Top module: `xlat_cache`

## Requirements
- R1: A valid lookup whose page and tag match a valid entry with sufficient rights asserts `lk_hit` in the same cycle, with that entry's frame on `lk_ppn` and its rights on `lk_perm`. When no lookup is valid, `lk_hit`, `lk_miss` and `lk_denied` are all low. `lk_ppn` and `lk_perm` are zero whenever `lk_hit` is low.
- R2: A valid lookup with no matching entry asserts `lk_miss`. If the walker control is in `ST_IDLE`, it moves to `ST_WALK` at the next edge. From the cycle after the miss, `walk_req` is high with `walk_vpn` and `walk_asid` holding the missed page and tag, and these stay stable until a fill. A miss seen during `ST_WALK` starts no new walk.
- R3: `fill_valid` in `ST_WALK` installs {walked page, walked tag, `fill_ppn`, `fill_perm`}, which is visible from the next cycle. It also returns the control to `ST_IDLE`. `fill_valid` in `ST_IDLE` is ignored.
- R4: Entries with the same page number and different tags coexist, and a lookup only matches the entry with its own tag.
- R5: Rights are coded as `perm[2]` writable, `perm[1]` user-accessible, `perm[0]` dirty. A matching lookup that writes a non-writable page, or that is a user access to a non-user page, asserts `lk_denied` only (no hit, no miss) and starts no walk.
- R6: A write lookup to a matching writable entry whose dirty bit is clear is a miss and launches a walk. The fill for a page and tag already present overwrites that entry in place.
- R7: `mnt_op`=1 removes every entry whose page equals `mnt_vpn`, whatever its tag, from the next cycle.
- R8: `mnt_op`=2 removes every entry whose tag equals `mnt_asid`, from the next cycle.
- R9: `mnt_op`=3 removes all entries, from the next cycle. `mnt_op`=0 is no operation.
- R10: A fill for a page and tag not yet present goes to the lowest-numbered invalid entry. Only when all entries are valid does it go to the entry under a rotating pointer. The pointer starts at entry 0 and advances by one, wrapping, only on such an eviction.
- R11: A fill in the same cycle as a maintenance operation that covers the walked page and tag (same page for 1, same tag for 2, any for 3) is dropped, while the control still returns to `ST_IDLE`. A fill that the operation does not cover is installed.
- R12: After reset, all entries are invalid, the control is in `ST_IDLE` and `walk_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_hit | output | 1 | Translation found with sufficient rights |
| lk_miss | output | 1 | No usable entry; walk needed |
| lk_denied | output | 1 | Entry found but rights are insufficient |
| lk_ppn | output | 20 | Frame number on hit, else zero |
| lk_perm | output | 3 | {writable, user, dirty} on hit, else zero |
| walk_req | output | 1 | Walk outstanding |
| walk_vpn | output | 20 | Page to walk |
| walk_asid | output | 8 | Tag of page to walk |
| fill_valid | input | 1 | Walker returns a result |
| fill_ppn | input | 20 | Frame from walker |
| fill_perm | input | 3 | Rights from walker, same coding as lk_perm |
| mnt_op | input | 2 | 0 none, 1 drop page, 2 drop tag, 3 drop all |
| mnt_vpn | input | 20 | Page for operation 1 |
| mnt_asid | input | 8 | Tag for operation 2 |

## Verification
The hardest situation to reach from the ports is a fill arriving in exactly the cycle that a maintenance operation hits the walked page. This needs a miss, a pending walk, and then both inputs raised together with a matching or non-matching operand. Directed steps build this case in both the covered and uncovered forms. A reference model in the bench tracks every entry and the rotating pointer, so that eviction order after mixed invalidations is predicted. The random phase then uses a page range of twelve values over three tags, which keeps the cache full and often makes maintenance collide with pending fills.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef struct packed {
        logic wr;
        logic usr;
        logic dty;
    } perm_t;

    typedef enum logic [1:0] {
        MNT_NONE  = 2'd0,
        MNT_PAGE  = 2'd1,
        MNT_SPACE = 2'd2,
        MNT_ALL   = 2'd3
    } mnt_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
    import xlat_pkg::*;
#(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PPN_W  = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      lk_match,
    output logic [PPN_W-1:0]  lk_ppn,
    output perm_t             lk_perm,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    output logic [N-1:0]      fl_match,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [PPN_W-1:0]  wppn,
    input  perm_t             wperm,
    input  mnt_op_e           kill_op,
    input  logic [VPN_W-1:0]  kill_vpn,
    input  logic [ASID_W-1:0] kill_asid,
    output logic [N-1:0]      valid_vec
);

    logic [N-1:0]      ent_v;
    logic [VPN_W-1:0]  ent_vpn  [N];
    logic [ASID_W-1:0] ent_asid [N];
    logic [PPN_W-1:0]  ent_ppn  [N];
    perm_t             ent_perm [N];
    logic [N-1:0]      kill;

    for (genvar g = 0; g < N; g++) begin : g_ent
        assign lk_match[g] = ent_v[g] && (ent_vpn[g] == lk_vpn) && (ent_asid[g] == lk_asid);
        assign fl_match[g] = ent_v[g] && (ent_vpn[g] == fl_vpn) && (ent_asid[g] == fl_asid);

        always_comb begin
            case (kill_op)
                MNT_PAGE:  kill[g] = ent_v[g] && (ent_vpn[g] == kill_vpn);
                MNT_SPACE: kill[g] = ent_v[g] && (ent_asid[g] == kill_asid);
                MNT_ALL:   kill[g] = ent_v[g];
                default:   kill[g] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            for (int i = 0; i < N; i++) begin
                ent_vpn[i]  <= '0;
                ent_asid[i] <= '0;
                ent_ppn[i]  <= '0;
                ent_perm[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we && (widx == IDX_W'(i))) begin
                    ent_v[i]    <= 1'b1;
                    ent_vpn[i]  <= fl_vpn;
                    ent_asid[i] <= fl_asid;
                    ent_ppn[i]  <= wppn;
                    ent_perm[i] <= wperm;
                end else if (kill[i]) begin
                    ent_v[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                lk_ppn  = lk_ppn | ent_ppn[i];
                lk_perm = lk_perm | ent_perm[i];
            end
        end
    end

    assign valid_vec = ent_v;

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
    parameter int N      = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     fl_match,
    input  logic             we,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] match_idx;
    logic             free_found;
    logic             use_ptr;

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        match_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (!free_found && !valid_vec[i]) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
            if (fl_match[i]) begin
                match_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        use_ptr = 1'b0;
        if (|fl_match) begin
            idx = match_idx;
        end else if (free_found) begin
            idx = free_idx;
        end else begin
            idx     = ptr;
            use_ptr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (we && use_ptr) begin
            ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
    import xlat_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_seen,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic              fill_valid,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [ASID_W-1:0] walk_asid,
    output logic              fill_take
);

    walk_state_e state, state_nx;
    logic        launch;

    always_comb begin
        state_nx = state;
        launch   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (miss_seen) begin
                    state_nx = ST_WALK;
                    launch   = 1'b1;
                end
            end
            ST_WALK: begin
                if (fill_valid) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            walk_vpn  <= '0;
            walk_asid <= '0;
        end else begin
            state <= state_nx;
            if (launch) begin
                walk_vpn  <= miss_vpn;
                walk_asid <= miss_asid;
            end
        end
    end

    always_comb begin
        walk_req  = 1'b0;
        fill_take = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WALK: begin
                walk_req  = 1'b1;
                fill_take = fill_valid;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PPN_W  = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_denied,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [2:0]        lk_perm,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [ASID_W-1:0] walk_asid,
    input  logic              fill_valid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [2:0]        fill_perm,
    input  logic [1:0]        mnt_op,
    input  logic [VPN_W-1:0]  mnt_vpn,
    input  logic [ASID_W-1:0] mnt_asid
);

    logic [N-1:0]     lk_match, fl_match, valid_vec;
    logic [PPN_W-1:0] ent_ppn;
    perm_t            ent_perm;
    logic             any_match, deny, clean_wr;
    logic             fill_take, covered, we;
    logic [IDX_W-1:0] widx;
    mnt_op_e          op;

    assign op = mnt_op_e'(mnt_op);

    xlat_entry_array #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .lk_asid   (lk_asid),
        .lk_match  (lk_match),
        .lk_ppn    (ent_ppn),
        .lk_perm   (ent_perm),
        .fl_vpn    (walk_vpn),
        .fl_asid   (walk_asid),
        .fl_match  (fl_match),
        .we        (we),
        .widx      (widx),
        .wppn      (fill_ppn),
        .wperm     (perm_t'(fill_perm)),
        .kill_op   (op),
        .kill_vpn  (mnt_vpn),
        .kill_asid (mnt_asid),
        .valid_vec (valid_vec)
    );

    // Lookup verdict: rights violation outranks the clean-write refill.
    assign any_match = |lk_match;
    assign deny      = (lk_write && !ent_perm.wr) || (lk_user && !ent_perm.usr);
    assign clean_wr  = lk_write && !ent_perm.dty;

    assign lk_hit    = lk_valid && any_match && !deny && !clean_wr;
    assign lk_denied = lk_valid && any_match && deny;
    assign lk_miss   = lk_valid && (!any_match || (!deny && clean_wr));
    assign lk_ppn    = lk_hit ? ent_ppn : '0;
    assign lk_perm   = lk_hit ? 3'(ent_perm) : 3'b000;

    xlat_walk_fsm #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_seen  (lk_miss),
        .miss_vpn   (lk_vpn),
        .miss_asid  (lk_asid),
        .fill_valid (fill_valid),
        .walk_req   (walk_req),
        .walk_vpn   (walk_vpn),
        .walk_asid  (walk_asid),
        .fill_take  (fill_take)
    );

    // A maintenance operation that reaches the walked page wins over the fill.
    always_comb begin
        case (op)
            MNT_PAGE:  covered = (mnt_vpn == walk_vpn);
            MNT_SPACE: covered = (mnt_asid == walk_asid);
            MNT_ALL:   covered = 1'b1;
            default:   covered = 1'b0;
        endcase
    end

    assign we = fill_take && !covered;

    xlat_victim_sel #(.N(N)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .fl_match  (fl_match),
        .we        (we),
        .idx       (widx)
    );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PPN_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_write,
    input logic              lk_user,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_denied,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [2:0]        lk_perm,
    input logic              walk_req,
    input logic [VPN_W-1:0]  walk_vpn,
    input logic [ASID_W-1:0] walk_asid,
    input logic              fill_valid,
    input logic [1:0]        mnt_op,
    input logic [VPN_W-1:0]  mnt_vpn,
    input logic [ASID_W-1:0] mnt_asid
);

    AST_QUIET_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> !(lk_hit || lk_miss || lk_denied || (lk_ppn != '0))); // R1
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |-> $onehot({lk_hit, lk_miss, lk_denied})); // R5
    AST_WALK_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n) $rose(walk_req) |-> $past(lk_valid && lk_miss)); // R2
    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vpn) && $stable(walk_asid))); // R2
    AST_FILL_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n) (walk_req && fill_valid) |=> !walk_req); // R3
    AST_USER_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n) (lk_hit && lk_user) |-> lk_perm[1]); // R5
    AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (lk_hit && lk_write) |-> (lk_perm[2] && lk_perm[0])); // R6
    AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n) (mnt_op == 2'd1) |=> !(lk_hit && (lk_vpn == $past(mnt_vpn)))); // R7
    AST_SPACE_GONE: assert property (@(posedge clk) disable iff (!rst_n) (mnt_op == 2'd2) |=> !(lk_hit && (lk_asid == $past(mnt_asid)))); // R8
    AST_ALL_GONE: assert property (@(posedge clk) disable iff (!rst_n) (mnt_op == 2'd3) |=> !(lk_hit || lk_denied)); // R9

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .lk_asid    (lk_asid),
    .lk_write   (lk_write),
    .lk_user    (lk_user),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_denied  (lk_denied),
    .lk_ppn     (lk_ppn),
    .lk_perm    (lk_perm),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .walk_asid  (walk_asid),
    .fill_valid (fill_valid),
    .mnt_op     (mnt_op),
    .mnt_vpn    (mnt_vpn),
    .mnt_asid   (mnt_asid)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_miss, lk_denied, walk_req;
    logic [19:0] lk_ppn, walk_vpn;
    logic [2:0]  lk_perm;
    logic [7:0]  walk_asid;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic [1:0]  mnt_op = '0;
    logic [19:0] mnt_vpn = '0;
    logic [7:0]  mnt_asid = '0;

    always #5 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_denied(lk_denied), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .walk_req(walk_req),
        .walk_vpn(walk_vpn), .walk_asid(walk_asid), .fill_valid(fill_valid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm), .mnt_op(mnt_op), .mnt_vpn(mnt_vpn),
        .mnt_asid(mnt_asid)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model
    bit        m_v    [8];
    bit [19:0] m_vpn  [8];
    bit [7:0]  m_asid [8];
    bit [19:0] m_ppn  [8];
    bit [2:0]  m_perm [8];
    int        m_ptr = 0;
    bit        m_walk = 0;
    bit [19:0] m_wvpn = '0;
    bit [7:0]  m_wasid = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int find(input bit [19:0] v, input bit [7:0] a);
        int r = -1;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) r = i;
        return r;
    endfunction

    // verdict code: 0 none, 4 hit, 2 miss, 1 denied
    function automatic bit [2:0] verdict(input bit lv, input bit [19:0] v, input bit [7:0] a,
                                         input bit w, input bit u);
        int k;
        if (!lv) return 3'b000;
        k = find(v, a);
        if (k < 0) return 3'b010;
        if ((w && !m_perm[k][2]) || (u && !m_perm[k][1])) return 3'b001;
        if (w && !m_perm[k][0]) return 3'b010;
        return 3'b100;
    endfunction

    task automatic model_edge(input bit lv, input bit [2:0] vd, input bit [19:0] v, input bit [7:0] a,
                              input bit [1:0] op, input bit [19:0] mv, input bit [7:0] ma,
                              input bit fv, input bit [19:0] fp, input bit [2:0] fpm);
        bit cov, acc;
        int vic;
        bit adv;
        acc = fv && m_walk;
        cov = (op == 2'd1 && mv == m_wvpn) || (op == 2'd2 && ma == m_wasid) || (op == 2'd3);
        vic = -1;
        adv = 0;
        if (acc && !cov) begin
            vic = find(m_wvpn, m_wasid);
            if (vic < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) vic = i;
            if (vic < 0) begin vic = m_ptr; adv = 1; end
        end
        for (int i = 0; i < 8; i++) begin
            if (m_v[i] && ((op == 2'd1 && m_vpn[i] == mv) || (op == 2'd2 && m_asid[i] == ma) || op == 2'd3))
                m_v[i] = 0;
        end
        if (vic >= 0) begin
            m_v[vic] = 1; m_vpn[vic] = m_wvpn; m_asid[vic] = m_wasid;
            m_ppn[vic] = fp; m_perm[vic] = fpm;
            if (adv) m_ptr = (m_ptr + 1) % 8;
        end
        if (m_walk) begin
            if (fv) m_walk = 0;
        end else if (lv && vd == 3'b010) begin
            m_walk = 1; m_wvpn = v; m_wasid = a;
        end
    endtask

    task automatic step(input bit lv, input bit [19:0] v, input bit [7:0] a, input bit w, input bit u,
                        input bit [1:0] op, input bit [19:0] mv, input bit [7:0] ma,
                        input bit fv, input bit [19:0] fp, input bit [2:0] fpm, input string tag);
        bit [2:0] vd;
        int k;
        string t;
        @(negedge clk);
        lk_valid = lv; lk_vpn = v; lk_asid = a; lk_write = w; lk_user = u;
        mnt_op = op; mnt_vpn = mv; mnt_asid = ma;
        fill_valid = fv; fill_ppn = fp; fill_perm = fpm;
        #1;
        vd = verdict(lv, v, a, w, u);
        t = tag;
        if (t == "") t = (vd == 3'b100) ? "R1" : (vd == 3'b001) ? "R5" : "R2";
        chk({lk_hit, lk_miss, lk_denied} == vd, t, {lk_hit, lk_miss, lk_denied}, vd);
        if (vd == 3'b100) begin
            k = find(v, a);
            chk(lk_ppn == m_ppn[k] && lk_perm == m_perm[k], t, {lk_perm, lk_ppn}, {m_perm[k], m_ppn[k]});
        end else begin
            chk(lk_ppn == 0 && lk_perm == 0, "R1", {lk_perm, lk_ppn}, 0);
        end
        chk(walk_req == m_walk, "R2", walk_req, m_walk);
        if (m_walk) chk(walk_vpn == m_wvpn && walk_asid == m_wasid, "R2", {walk_asid, walk_vpn}, {m_wasid, m_wvpn});
        model_edge(lv, vd, v, a, op, mv, ma, fv, fp, fpm);
    endtask

    task automatic look(input bit [19:0] v, input bit [7:0] a, input bit w, input bit u, input string tag);
        step(1, v, a, w, u, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input bit [19:0] p, input bit [2:0] pm, input bit [1:0] op,
                        input bit [19:0] mv, input bit [7:0] ma, input string tag);
        step(0, 0, 0, 0, 0, op, mv, ma, 1, p, pm, tag);
    endtask

    task automatic maint(input bit [1:0] op, input bit [19:0] mv, input bit [7:0] ma, input string tag);
        step(0, 0, 0, 0, 0, op, mv, ma, 0, 0, 0, tag);
    endtask

    task automatic walk_fill(input bit [19:0] v, input bit [7:0] a, input bit [19:0] p,
                             input bit [2:0] pm, input string tag);
        look(v, a, 0, 0, tag);
        fill(p, pm, 0, 0, 0, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R12: empty after reset
        chk(walk_req == 0, "R12", walk_req, 0);
        chk({lk_hit, lk_miss, lk_denied} == 0, "R12", {lk_hit, lk_miss, lk_denied}, 0);
        look(20'h00100, 8'd1, 0, 0, "R12");

        // R2/R3/R1: miss, walk, fill, hit; fill while idle ignored
        fill(20'hABCDE, 3'b111, 0, 0, 0, "R2");
        fill(20'h55555, 3'b111, 0, 0, 0, "R3");
        look(20'h00100, 8'd1, 0, 0, "R1");
        look(20'h00100, 8'd1, 1, 1, "R1");

        // R4: same page, other tag
        look(20'h00100, 8'd2, 0, 0, "R4");
        fill(20'h11111, 3'b111, 0, 0, 0, "R4");
        look(20'h00100, 8'd2, 0, 0, "R4");
        look(20'h00100, 8'd1, 0, 0, "R4");

        // R5: read-only supervisor clean page
        walk_fill(20'h00200, 8'd1, 20'h22222, 3'b000, "R5");
        look(20'h00200, 8'd1, 1, 0, "R5");
        look(20'h00200, 8'd1, 0, 1, "R5");
        look(20'h00200, 8'd1, 0, 0, "R5");
        chk(walk_req == 0, "R5", walk_req, 0);

        // R6: writable clean page -> write misses, refill in place
        walk_fill(20'h00300, 8'd1, 20'h33333, 3'b110, "R6");
        look(20'h00300, 8'd1, 1, 1, "R6");
        fill(20'h33334, 3'b111, 0, 0, 0, "R6");
        look(20'h00300, 8'd1, 1, 1, "R6");

        // R7: drop page under all tags
        maint(2'd1, 20'h00100, 0, "R7");
        look(20'h00100, 8'd1, 0, 0, "R7");
        look(20'h00100, 8'd2, 0, 0, "R7");
        look(20'h00200, 8'd1, 0, 0, "R7");

        // R11: covered fill dropped, uncovered fill kept
        fill(20'h44444, 3'b111, 2'd1, 20'h00100, 0, "R11");
        look(20'h00100, 8'd1, 0, 0, "R11");
        fill(20'h44445, 3'b111, 2'd1, 20'h00999, 0, "R11");
        look(20'h00100, 8'd1, 0, 0, "R11");

        // R8: drop one tag
        walk_fill(20'h00100, 8'd2, 20'h66666, 3'b111, "R8");
        maint(2'd2, 0, 8'd2, "R8");
        look(20'h00100, 8'd2, 0, 0, "R8");
        look(20'h00100, 8'd1, 0, 0, "R8");
        fill(20'h66667, 3'b111, 0, 0, 0, "R8");

        // R9: drop all
        maint(2'd3, 0, 0, "R9");
        look(20'h00100, 8'd1, 0, 0, "R9");
        look(20'h00300, 8'd1, 0, 0, "R9");
        fill(20'h77777, 3'b111, 2'd3, 0, 0, "R9");
        look(20'h00100, 8'd1, 0, 0, "R9");
        fill(20'h77778, 3'b101, 0, 0, 0, "R9");

        // R10: fill all, evict by pointer, invalid slot preferred
        maint(2'd3, 0, 0, "R10");
        for (int i = 0; i < 8; i++) walk_fill(20'h00010 + i, 8'd3, 20'h80000 + i, 3'b111, "R10");
        walk_fill(20'h00018, 8'd3, 20'h80008, 3'b111, "R10");
        for (int i = 0; i < 9; i++) look(20'h00010 + i, 8'd3, 0, 0, "R10");
        fill(20'h80010, 3'b111, 0, 0, 0, "R10");
        maint(2'd1, 20'h00014, 0, "R10");
        walk_fill(20'h00020, 8'd3, 20'h80020, 3'b111, "R10");
        for (int i = 0; i < 9; i++) look(20'h00010 + i, 8'd3, 0, 0, "R10");
        look(20'h00020, 8'd3, 0, 0, "R10");
        if (m_walk) fill(20'h80030, 3'b111, 0, 0, 0, "R10");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit lv, w, u, fv;
            bit [1:0] op;
            int r;
            lv = ($urandom % 4) != 0;
            w  = $urandom % 2;
            u  = ($urandom % 3) == 0;
            r  = $urandom % 50;
            op = (r < 3) ? 2'd1 : (r < 5) ? 2'd2 : (r == 5) ? 2'd3 : 2'd0;
            fv = m_walk ? (($urandom % 3) == 0) : (($urandom % 10) == 0);
            step(lv, 20'h00040 + 20'($urandom % 12), 8'($urandom % 3), w, u,
                 op, 20'h00040 + 20'($urandom % 12), 8'($urandom % 3),
                 fv, 20'($urandom), 3'($urandom), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule